// File: doc/BRIEF.md
# IEEE 1284 Multi-Mode Port Engine

This block is the per-port engine of a host parallel-port controller. It sits between a simple register bus (a 3-bit address, one-cycle write and read strobes, combinational read data) and the peripheral-side pins. It drives the 8-bit data lines and their direction. It drives four active-low control lines, modelled as levels where 1 means released (open drain with pull-up). It samples five status inputs. A 3-bit mode field in the extended control register selects how the pins behave:

- compatibility (000)
- byte, bidirectional (001)
- EPP with hardware strobes (100)
- FIFO test (110)
- configuration access (111)

Software drives a printer or peripheral in compatibility or byte mode through the data and control registers. It uses EPP mode for handshaked address and data cycles that the engine sequences by itself. It uses the FIFO test mode to exercise the 16-byte FIFO without disturbing the peripheral, and the configuration mode to reach the two configuration registers. Reverse-channel nibbles arriving on the status lines are packed into bytes on each falling edge of the acknowledge input. The same edge can raise an interrupt.

Register addresses: 0 data, 1 status, 2 control, 3 EPP address, 4 EPP data, 5 FIFO / config-A / nibble byte, 6 config-B, 7 extended control (ECR).

Top module: `pport_engine`

## Requirements
- R1: After reset the mode is byte (001), the control register is 0, all four control lines read 1, pd_dir is 1, irq is 0, and ECR reads 0x21. ECR layout: bits 7:5 mode, bit 1 FIFO full, bit 0 FIFO empty, other bits 0.
- R2: An ECR write changes the mode only if the current mode is 000 or 001, or the requested mode is 000 or 001, or it equals the current mode. Requested codes 010, 011 and 101 are always rejected. A rejected write leaves the mode unchanged.
- R3: In compatibility mode the data lines are always driven (pd_dir=1) whatever control bit 5 holds. Control bits 0, 1, 2 and 3 set to 1 pull strobe_n, autofd_n, init_n and selin_n low respectively. pd_out shows the data register, and a data read returns it.
- R4: In byte mode and configuration mode, pd_dir is the inverse of control bit 5. While the lines are released, a data read returns pd_in.
- R5: In EPP mode, a write to address 3 (or 4) loads the byte onto pd_out and starts a cycle. During the cycle strobe_n is low, selin_n (address) or autofd_n (data) is low, and pd_dir is 1. The strobe is held until busy_in is seen high at a clock edge.
- R6: In EPP mode, a read of address 3 or 4 returns the byte captured by the previous EPP read cycle (0 after reset) and starts a read cycle. During this cycle strobe_n is 1 and pd_dir is 0, and pd_in is captured at the edge where busy_in is high.
- R7: If busy_in stays low, an EPP cycle aborts after config-B[3:0]+1 clock edges (reset value 8). The abort releases the strobes and sets status bit 0. That bit is cleared by the next status read.
- R8: In FIFO test mode, address-5 writes push and address-5 reads pop a 16-byte FIFO in order. pd_out shows the oldest byte. A push into a full FIFO is dropped. strobe_n and autofd_n stay 1 whatever the control register holds.
- R9: Only in configuration mode does address 5 read config-A, a constant 0x10 plus log2 of the FIFO depth (0x14). In that mode config-B at address 6 is readable and writable. In other modes config-B writes are ignored and address 6 reads 0.
- R10: On each falling edge of ack_n_in the nibble {busy,pe,slct,fault_n} is stored alternately into bits 3:0 and then bits 7:4 of the nibble byte. In modes 000, 001 and 100, address 5 reads that byte, and the read restarts at the low nibble.
- R11: A falling edge of ack_n_in sets irq and status bit 2 only when control bit 4 is 1. A status read clears both.
- R12: The status register reads {busy_in, ack_n_in, pe_in, slct_in, fault_n_in, irq, 0, timeout} from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe (pops, clears take effect at the edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| pd_in | input | 8 | Data lines as seen on the pins |
| pd_out | output | 8 | Data driven onto the lines |
| pd_dir | output | 1 | 1 = engine drives the data lines |
| strobe_n | output | 1 | Strobe / EPP write indicator, 1 = released |
| autofd_n | output | 1 | Auto feed / EPP data strobe, 1 = released |
| init_n | output | 1 | Initialise peripheral, 1 = released |
| selin_n | output | 1 | Select / EPP address strobe, 1 = released |
| busy_in | input | 1 | Peripheral busy / EPP wait |
| ack_n_in | input | 1 | Peripheral acknowledge, active low |
| pe_in | input | 1 | Paper empty |
| slct_in | input | 1 | Peripheral selected |
| fault_n_in | input | 1 | Peripheral fault, active low |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the status inputs are already synchronous to clk and that bus_wr and bus_rd are never high together. They also assume the host stays within the register map, so no EPP access is issued outside EPP mode. The stimulus keeps within these limits by changing every input one nanosecond after a rising edge. It issues one bus access per task call, and holds ack_n_in low for at least two clocks so each falling edge is seen once. busy_in is raised only while an EPP cycle is active, except in the timeout case, where it is deliberately kept low.

// File: rtl/pport_pkg.sv
`timescale 1ns/1ps
package pport_pkg;
  // mode codes; the base pair 000/001 gates every transition
  localparam logic [2:0] PM_SPP   = 3'b000;
  localparam logic [2:0] PM_BYTE  = 3'b001;
  localparam logic [2:0] PM_EPP   = 3'b100;
  localparam logic [2:0] PM_FTEST = 3'b110;
  localparam logic [2:0] PM_CFG   = 3'b111;

  localparam logic [2:0] RA_DATA  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_CTRL  = 3'd2;
  localparam logic [2:0] RA_EADDR = 3'd3;
  localparam logic [2:0] RA_EDATA = 3'd4;
  localparam logic [2:0] RA_FIFO  = 3'd5;
  localparam logic [2:0] RA_CFGB  = 3'd6;
  localparam logic [2:0] RA_ECR   = 3'd7;

  localparam int CB_STB = 0;
  localparam int CB_AFD = 1;
  localparam int CB_INIT = 2;
  localparam int CB_SEL = 3;
  localparam int CB_IRQEN = 4;
  localparam int CB_DIR = 5;
  localparam int CTRL_W = 6;

  function automatic logic code_ok(input logic [2:0] c);
    return (c == PM_SPP) || (c == PM_BYTE) || (c == PM_EPP) ||
           (c == PM_FTEST) || (c == PM_CFG);
  endfunction

  function automatic logic is_base(input logic [2:0] c);
    return c[2:1] == 2'b00;
  endfunction

  function automatic logic [2:0] mode_next(input logic [2:0] cur, input logic [2:0] req);
    if (!code_ok(req)) return cur;
    if (req == cur || is_base(cur) || is_base(req)) return req;
    return cur;
  endfunction

  function automatic logic [3:0] nibble_of(input logic busy, input logic pe,
                                           input logic slct, input logic fault_n);
    return {busy, pe, slct, fault_n};
  endfunction

  function automatic logic [7:0] cfga_word(input int depth);
    return {4'h1, 4'($clog2(depth))};
  endfunction
endpackage

// File: rtl/pport_mode_reg.sv
`timescale 1ns/1ps
module pport_mode_reg
  import pport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] req,
  output logic [2:0] mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= PM_BYTE;
    else if (wr_en) mode <= mode_next(mode, req);
  end

  a_r2_legal_path: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ($past(mode[2:1]) == 2'b00 || mode[2:1] == 2'b00));
  a_r2_reserved_never: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode == 3'b010 || mode == 3'b011 || mode == 3'b101));
endmodule

// File: rtl/pport_fifo.sv
`timescale 1ns/1ps
module pport_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_do, pop_do;

  assign full    = count == CW'(DEPTH);
  assign empty   = count == '0;
  assign push_do = push && !full;
  assign pop_do  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_do) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_do) wr_ptr <= wr_ptr + 1'b1;
      if (pop_do)  rd_ptr <= rd_ptr + 1'b1;
      if (push_do && !pop_do) count <= count + 1'b1;
      else if (pop_do && !push_do) count <= count - 1'b1;
    end
  end

  a_r8_empty_by_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(pop_do));
  a_r8_full_by_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(push_do));
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full && $stable(wr_ptr));
endmodule

// File: rtl/pport_epp_hs.sv
`timescale 1ns/1ps
module pport_epp_hs #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_addr,
  input  logic             is_write,
  input  logic [CNT_W-1:0] limit,
  input  logic             busy_in,
  input  logic [7:0]       pd_in,
  output logic             active,
  output logic             wr_cyc,
  output logic             astb,
  output logic             dstb,
  output logic             tmo_evt,
  output logic [7:0]       rx_data
);
  typedef enum logic {HS_IDLE, HS_STB} hs_e;
  hs_e              st;
  logic [CNT_W-1:0] cnt;
  logic             addr_q, wr_q;
  logic             done_evt;

  assign active   = st == HS_STB;
  assign wr_cyc   = active && wr_q;
  assign astb     = active && addr_q;
  assign dstb     = active && !addr_q;
  assign done_evt = active && busy_in;
  assign tmo_evt  = active && !busy_in && cnt == limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= HS_IDLE;
      cnt     <= '0;
      addr_q  <= 1'b0;
      wr_q    <= 1'b0;
      rx_data <= '0;
    end else if (!active) begin
      if (start) begin
        st     <= HS_STB;
        cnt    <= '0;
        addr_q <= is_addr;
        wr_q   <= is_write;
      end
    end else if (done_evt) begin
      st <= HS_IDLE;
      if (!wr_q) rx_data <= pd_in;
    end else if (tmo_evt) begin
      st <= HS_IDLE;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r5_hold_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !busy_in && cnt != limit) |=> active);
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({astb, dstb}));
  a_r7_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !active);
endmodule

// File: rtl/pport_engine.sv
`timescale 1ns/1ps
module pport_engine
  import pport_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TMO_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  output logic       pd_dir,
  output logic       strobe_n,
  output logic       autofd_n,
  output logic       init_n,
  output logic       selin_n,
  input  logic       busy_in,
  input  logic       ack_n_in,
  input  logic       pe_in,
  input  logic       slct_in,
  input  logic       fault_n_in,
  output logic       irq
);
  localparam logic [7:0] CFGA_VAL  = cfga_word(FIFO_DEPTH);
  localparam logic [7:0] CFGB_INIT = 8'h08;

  logic [2:0]        mode;
  logic [CTRL_W-1:0] ctrl_q;
  logic [7:0]        data_q, cfgb_q, nib_q;
  logic              tmo_flag, irq_q, ack_prev, nib_hi;
  logic              in_epp, in_ftest, in_cfg;
  logic              wr_ctrl, wr_data, wr_ecr, wr_cfgb, rd_stat, rd_slot;
  logic              epp_hit, epp_start, epp_active, epp_wr, epp_astb, epp_dstb, epp_tmo;
  logic [7:0]        epp_rx, fifo_dout;
  logic              fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic              ack_fall;

  assign in_epp   = mode == PM_EPP;
  assign in_ftest = mode == PM_FTEST;
  assign in_cfg   = mode == PM_CFG;

  assign wr_data = bus_wr && bus_addr == RA_DATA;
  assign wr_ctrl = bus_wr && bus_addr == RA_CTRL;
  assign wr_ecr  = bus_wr && bus_addr == RA_ECR;
  assign wr_cfgb = bus_wr && bus_addr == RA_CFGB && in_cfg;
  assign rd_stat = bus_rd && bus_addr == RA_STAT;
  assign rd_slot = bus_rd && bus_addr == RA_FIFO && !in_ftest && !in_cfg;

  assign epp_hit   = bus_addr == RA_EADDR || bus_addr == RA_EDATA;
  assign epp_start = in_epp && !epp_active && epp_hit && (bus_wr || bus_rd);

  assign fifo_push = in_ftest && bus_wr && bus_addr == RA_FIFO;
  assign fifo_pop  = in_ftest && bus_rd && bus_addr == RA_FIFO;

  assign ack_fall = ack_prev && !ack_n_in;

  pport_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ecr), .req(bus_wdata[7:5]), .mode(mode)
  );

  pport_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop), .din(bus_wdata),
    .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty)
  );

  pport_epp_hs #(.CNT_W(TMO_W)) u_epp (
    .clk(clk), .rst_n(rst_n), .start(epp_start), .is_addr(bus_addr == RA_EADDR),
    .is_write(bus_wr), .limit(cfgb_q[TMO_W-1:0]), .busy_in(busy_in), .pd_in(pd_in),
    .active(epp_active), .wr_cyc(epp_wr), .astb(epp_astb), .dstb(epp_dstb),
    .tmo_evt(epp_tmo), .rx_data(epp_rx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      data_q   <= '0;
      cfgb_q   <= CFGB_INIT;
      tmo_flag <= 1'b0;
      irq_q    <= 1'b0;
      ack_prev <= 1'b1;
      nib_q    <= '0;
      nib_hi   <= 1'b0;
    end else begin
      ack_prev <= ack_n_in;
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_data || (epp_start && bus_wr)) data_q <= bus_wdata;
      if (wr_cfgb) cfgb_q <= bus_wdata;
      if (epp_tmo) tmo_flag <= 1'b1;
      else if (rd_stat) tmo_flag <= 1'b0;
      if (ack_fall && ctrl_q[CB_IRQEN]) irq_q <= 1'b1;
      else if (rd_stat) irq_q <= 1'b0;
      if (ack_fall) begin
        if (nib_hi) nib_q[7:4] <= nibble_of(busy_in, pe_in, slct_in, fault_n_in);
        else        nib_q[3:0] <= nibble_of(busy_in, pe_in, slct_in, fault_n_in);
        nib_hi <= !nib_hi;
      end else if (rd_slot) begin
        nib_hi <= 1'b0;
      end
    end
  end

  always_comb begin
    pd_out   = in_ftest ? fifo_dout : data_q;
    strobe_n = !ctrl_q[CB_STB];
    autofd_n = !ctrl_q[CB_AFD];
    init_n   = !ctrl_q[CB_INIT];
    selin_n  = !ctrl_q[CB_SEL];
    pd_dir   = !ctrl_q[CB_DIR];
    case (mode)
      PM_SPP: pd_dir = 1'b1;
      PM_EPP: begin
        pd_dir   = !(epp_active && !epp_wr);
        strobe_n = !epp_wr;
        autofd_n = !epp_dstb;
        selin_n  = !epp_astb;
      end
      PM_FTEST: begin
        pd_dir   = 1'b1;
        strobe_n = 1'b1;
        autofd_n = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (bus_addr)
      RA_DATA:  bus_rdata = pd_dir ? pd_out : pd_in;
      RA_STAT:  bus_rdata = {busy_in, ack_n_in, pe_in, slct_in, fault_n_in, irq_q, 1'b0, tmo_flag};
      RA_CTRL:  bus_rdata = 8'(ctrl_q);
      RA_EADDR, RA_EDATA: bus_rdata = in_epp ? epp_rx : 8'h00;
      RA_FIFO:  bus_rdata = in_cfg ? CFGA_VAL : (in_ftest ? fifo_dout : nib_q);
      RA_CFGB:  bus_rdata = in_cfg ? cfgb_q : 8'h00;
      default:  bus_rdata = {mode, 3'b000, fifo_full, fifo_empty};
    endcase
  end

  assign irq = irq_q;

  a_r3_spp_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SPP) |-> pd_dir);
  a_r11_irq_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ack_fall));
  a_r7_tmo_from_epp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(mode) == PM_EPP);
  a_r5_epp_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    in_epp |-> (selin_n || autofd_n));
endmodule

// File: tb/pport_engine_tb.sv
`timescale 1ns/1ps
module pport_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pd_in = 8'hA5;
  logic [7:0] pd_out;
  logic       pd_dir, strobe_n, autofd_n, init_n, selin_n, irq;
  logic       busy_in = 1'b0, ack_n_in = 1'b1, pe_in = 1'b0, slct_in = 1'b1, fault_n_in = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  pport_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_in(pd_in), .pd_out(pd_out),
    .pd_dir(pd_dir), .strobe_n(strobe_n), .autofd_n(autofd_n), .init_n(init_n),
    .selin_n(selin_n), .busy_in(busy_in), .ack_n_in(ack_n_in), .pe_in(pe_in),
    .slct_in(slct_in), .fault_n_in(fault_n_in), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per read strobe
  always @(negedge clk) begin
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: actual 0x%0h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), int'(bus_rdata), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    wr(3'd7, {m, 5'b0});
  endtask

  task automatic epp_ack();
    @(posedge clk); #1; busy_in = 1'b1;
    @(posedge clk); #1; busy_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack_pulse();
    @(posedge clk); #1; ack_n_in = 1'b0;
    repeat (2) @(posedge clk);
    #1; ack_n_in = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 lines", {strobe_n, autofd_n, init_n, selin_n}, 4'hF);
    chk("R1 pd_dir", pd_dir, 1);
    chk("R1 irq", irq, 0);
    rd(3'd7, 8'h21, "R1 ecr");
    rd(3'd2, 8'h00, "R1 ctrl");
    rd(3'd6, 8'h00, "R9 cfgb hidden");

    // R2 transition path
    set_mode(3'b100); rd(3'd7, 8'h81, "R2 byte->epp");
    set_mode(3'b110); rd(3'd7, 8'h81, "R2 epp->ftest rejected");
    set_mode(3'b011); rd(3'd7, 8'h81, "R2 reserved rejected");
    set_mode(3'b000); rd(3'd7, 8'h01, "R2 epp->spp");
    set_mode(3'b010); rd(3'd7, 8'h01, "R2 reserved from base");

    // R3 compatibility
    wr(3'd2, 8'h2F); wr(3'd0, 8'h3C);
    @(negedge clk);
    chk("R3 pd_dir forced", pd_dir, 1);
    chk("R3 lines follow ctrl", {strobe_n, autofd_n, init_n, selin_n}, 4'h0);
    chk("R3 pd_out", pd_out, 8'h3C);
    rd(3'd0, 8'h3C, "R3 data read");

    // R4 byte mode
    set_mode(3'b001);
    @(negedge clk);
    chk("R4 reverse", pd_dir, 0);
    rd(3'd0, 8'hA5, "R4 data from pins");
    wr(3'd2, 8'h00);
    @(negedge clk);
    chk("R4 forward", pd_dir, 1);
    rd(3'd0, 8'h3C, "R4 data latch");

    // R5 EPP writes
    set_mode(3'b100);
    wr(3'd3, 8'h5A);
    @(negedge clk);
    chk("R5 addr strobe", {strobe_n, autofd_n, selin_n, pd_dir}, 4'b0101);
    chk("R5 addr byte", pd_out, 8'h5A);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 held", selin_n, 0);
    epp_ack();
    chk("R5 addr released", {strobe_n, selin_n}, 2'b11);
    wr(3'd4, 8'hC3);
    @(negedge clk);
    chk("R5 data strobe", {strobe_n, autofd_n, selin_n}, 3'b001);
    chk("R5 data byte", pd_out, 8'hC3);
    epp_ack();
    chk("R5 data released", autofd_n, 1);

    // R6 EPP reads
    pd_in = 8'h96;
    rd(3'd4, 8'h00, "R6 first read");
    @(negedge clk);
    chk("R6 read cycle", {strobe_n, autofd_n, pd_dir}, 3'b100);
    epp_ack();
    rd(3'd4, 8'h96, "R6 captured");
    epp_ack();

    // R7 timeout, R12 layout
    wr(3'd4, 8'h11);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R7 still waiting", autofd_n, 0);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R7 aborted", autofd_n, 1);
    rd(3'd1, 8'h59, "R7 R12 status tmo");
    rd(3'd1, 8'h58, "R7 tmo cleared");

    // R9 config access
    set_mode(3'b001); set_mode(3'b111);
    rd(3'd5, 8'h14, "R9 cfga");
    rd(3'd6, 8'h08, "R9 cfgb reset");
    wr(3'd6, 8'h02); rd(3'd6, 8'h02, "R9 cfgb write");
    wr(3'd5, 8'hFF); rd(3'd5, 8'h14, "R9 cfga read only");
    set_mode(3'b001);
    wr(3'd6, 8'h07); rd(3'd6, 8'h00, "R9 cfgb hidden");
    set_mode(3'b111); rd(3'd6, 8'h02, "R9 cfgb kept");

    // R8 FIFO test
    set_mode(3'b001); set_mode(3'b110);
    rd(3'd7, 8'hC1, "R8 empty");
    wr(3'd2, 8'h03);
    for (int i = 0; i < 16; i++) begin
      wr(3'd5, 8'(i * 7 + 3));
      if (i == 0) begin
        @(negedge clk);
        chk("R8 head on pd", pd_out, 8'h03);
      end
    end
    rd(3'd7, 8'hC2, "R8 full");
    wr(3'd5, 8'hEE);
    @(negedge clk);
    chk("R8 no strobes", {strobe_n, autofd_n}, 2'b11);
    for (int i = 0; i < 16; i++) rd(3'd5, 8'(i * 7 + 3), "R8 order");
    rd(3'd7, 8'hC1, "R8 drained");
    wr(3'd2, 8'h00);

    // R10 nibble packing, R11 disabled
    set_mode(3'b001);
    rd(3'd5, 8'h00, "R10 initial");
    busy_in = 1'b1; pe_in = 1'b0; slct_in = 1'b1; fault_n_in = 1'b0;
    ack_pulse();
    busy_in = 1'b0; pe_in = 1'b1; slct_in = 1'b1; fault_n_in = 1'b1;
    ack_pulse();
    pe_in = 1'b0;
    @(negedge clk);
    chk("R11 masked", irq, 0);
    rd(3'd5, 8'h7A, "R10 packed");

    // R11 enabled
    wr(3'd2, 8'h10);
    ack_pulse();
    @(negedge clk);
    chk("R11 raised", irq, 1);
    rd(3'd1, 8'h5C, "R11 R12 status irq");
    @(negedge clk);
    chk("R11 cleared", irq, 0);
    rd(3'd1, 8'h58, "R11 status after clear");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule